// File: doc/BRIEF.md
# Framed Serial Packet Receiver

This block takes a single NRZ serial line from a remote module whose bit clock is derived from the same source as the local system clock. Bit frequency is therefore known and only phase is uncertain. The line rests high. A packet is one low start bit followed by 256 data bits. The receiver arms itself only after the line has stayed high for a configurable quiet interval. The payload is built so that such a quiet stretch can never occur inside a packet.

Once armed, the receiver treats a falling edge as a candidate start bit and confirms it at mid-bit. It then discards the start bit and samples each data bit half a bit period after the most recent line transition. Every transition re-aligns the sampling phase, so slow drift between the two ends cannot build up. Bits are packed most significant bit first into 16-bit words. The words go into a 16-entry buffer that a processor reads through a word address. A ready flag tells the processor that a complete packet is waiting. While that flag is set the buffer is frozen, and any further packet is thrown away and recorded as an overrun. A one-cycle acknowledge clears both flags.

Top module: `frame_rx`

## Requirements
- R1: After reset, `pkt_ready` and `overrun` are both 0.
- R2: A falling edge starts a packet only if the line has been high for at least `IDLE_TICKS` system clocks beforehand. This also holds after reset, where the count starts from zero, so a packet sent too soon after reset is ignored and `pkt_ready` stays 0.
- R3: If the line rises again before the middle of the start bit, the event is a glitch. The receiver goes back to hunting, and a later correctly framed packet is received intact.
- R4: The 256 data bits after the start bit fill words 0 to 15 in arrival order, most significant bit first. Word n is read on `rd_data` when `rd_addr` equals n.
- R5: `pkt_ready` rises when the last data bit of an accepted packet has been sampled. It stays 1 until `ack` is pulsed, and it is 0 in the cycle after the pulse.
- R6: A packet that starts while `pkt_ready` is 1 leaves the buffer unchanged and sets `overrun`. `ack` clears `overrun`.
- R7: Each data bit is sampled half a bit period after the latest line transition, so packets are received correctly when the sender's bit period differs from `BIT_TICKS` by one clock, provided no run of identical bits exceeds two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial data line, high when idle |
| ack | input | 1 | One-cycle pulse: buffer consumed, clears flags |
| rd_addr | input | 4 | Word index into the packet buffer |
| rd_data | output | 16 | Buffer word selected by `rd_addr` |
| pkt_ready | output | 1 | A complete packet is held in the buffer |
| overrun | output | 1 | A packet was dropped while the buffer was held |

## Verification
The line passes through two synchronizer flops before the framer sees it. The last data bit is therefore sampled two clocks after its mid-point, and `pkt_ready` or `overrun` changes one clock after that. This is always within the first three clocks after the last bit ends. The bench drives the line on falling clock edges and examines flags and buffer words four clocks after a packet's final bit. `rd_data` is combinational on `rd_addr`, so each word is sampled 1 ns after the address changes. Flag clearing by `ack` is checked on the falling edge that follows the pulse's capturing edge.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [1:0] {
    FR_HUNT  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/frx_line_sync.sv
module frx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_lvl,
  output logic rx_edge,
  output logic rx_fall
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign rx_lvl  = pipe_q[STAGES-1];
  assign rx_edge = pipe_q[STAGES-1] ^ pipe_q[STAGES];
  assign rx_fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/frx_idle_timer.sv
module frx_idle_timer #(
  parameter int IDLE_TICKS = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  output logic idle_ok
);
  localparam int CW = $clog2(IDLE_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign idle_ok = (cnt_q == CW'(IDLE_TICKS));

  always_comb begin
    if (!line_hi)     cnt_d = '0;
    else if (idle_ok) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Quiet interval can only be reported after the line was seen high
  assert_idle_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok |-> $past(line_hi));
endmodule

// File: rtl/frx_framer.sv
module frx_framer
  import frx_pkg::*;
#(
  parameter int BIT_TICKS = 125,
  parameter int WORDS     = 16,
  parameter int WORD_W    = 16,
  localparam int IW       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_lvl,
  input  logic              rx_edge,
  input  logic              rx_fall,
  input  logic              idle_ok,
  input  logic              hold,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [WORD_W-1:0] wr_word,
  output logic              pkt_done,
  output logic              pkt_drop
);
  localparam int NBITS = WORDS * WORD_W;
  localparam int BW    = $clog2(NBITS);
  localparam int WB    = $clog2(WORD_W);
  localparam int PW    = $clog2(BIT_TICKS);
  localparam int HALF  = BIT_TICKS / 2;

  fr_state_e       st_q, st_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic [BW-1:0]   bc_q, bc_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic            dr_q, dr_d;
  logic            sample;
  logic            word_end;
  logic            last_bit;

  assign sample   = (ph_q == '0) && !rx_edge;
  assign word_end = &bc_q[WB-1:0];
  assign last_bit = (bc_q == BW'(NBITS - 1));
  assign wr_idx   = bc_q[BW-1:WB];
  assign wr_word  = {sh_q[WORD_W-2:0], rx_lvl};
  assign pkt_drop = dr_q;

  always_comb begin
    st_d     = st_q;
    bc_d     = bc_q;
    sh_d     = sh_q;
    dr_d     = dr_q;
    wr_en    = 1'b0;
    pkt_done = 1'b0;
    if (rx_edge)         ph_d = PW'(HALF - 1);
    else if (ph_q == '0) ph_d = PW'(BIT_TICKS - 1);
    else                 ph_d = ph_q - 1'b1;
    case (st_q)
      FR_HUNT: begin
        if (rx_fall && idle_ok) begin
          st_d = FR_START;
          dr_d = hold;
        end
      end
      FR_START: begin
        if (rx_edge) st_d = FR_HUNT;
        else if (sample) begin
          if (!rx_lvl) begin
            st_d = FR_DATA;
            bc_d = '0;
          end else begin
            st_d = FR_HUNT;
          end
        end
      end
      FR_DATA: begin
        if (sample) begin
          sh_d = {sh_q[WORD_W-2:0], rx_lvl};
          bc_d = bc_q + 1'b1;
          if (word_end) wr_en = !dr_q;
          if (last_bit) begin
            pkt_done = 1'b1;
            st_d     = FR_HUNT;
          end
        end
      end
      default: st_d = FR_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FR_HUNT;
      ph_q <= '0;
      bc_q <= '0;
      sh_q <= '0;
      dr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      bc_q <= bc_d;
      sh_q <= sh_d;
      dr_q <= dr_d;
    end
  end

  // Entry into start confirmation only from an armed hunt
  assert_start_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_START && $past(st_q) == FR_HUNT) |-> $past(idle_ok));
  // A transition during start confirmation abandons the frame
  assert_glitch_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_START && rx_edge) |=> (st_q == FR_HUNT));
  // Buffer writes only happen while collecting data
  assert_write_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st_q == FR_DATA));
endmodule

// File: rtl/frx_buffer.sv
module frx_buffer #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 16,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) mem_q[g] <= wr_word;
    end
  end

  assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int BIT_TICKS   = 125,
  parameter int IDLE_TICKS  = 16000,
  parameter int SYNC_STAGES = 2,
  parameter int WORDS       = 16,
  parameter int WORD_W      = 16,
  localparam int AW         = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              ack,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              pkt_ready,
  output logic              overrun
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              rx_lvl, rx_edge, rx_fall, idle_ok;
  logic              wr_en, pkt_done, pkt_drop;
  logic [AW-1:0]     wr_idx;
  logic [WORD_W-1:0] wr_word;
  logic              rdy_d, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  frx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .rx_in(rx_line),
    .rx_lvl(rx_lvl), .rx_edge(rx_edge), .rx_fall(rx_fall));

  frx_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_s_n), .line_hi(rx_lvl), .idle_ok(idle_ok));

  frx_framer #(.BIT_TICKS(BIT_TICKS), .WORDS(WORDS), .WORD_W(WORD_W)) u_framer (
    .clk(clk), .rst_n(rst_s_n), .rx_lvl(rx_lvl), .rx_edge(rx_edge),
    .rx_fall(rx_fall), .idle_ok(idle_ok), .hold(pkt_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .pkt_done(pkt_done), .pkt_drop(pkt_drop));

  frx_buffer #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .rd_idx(rd_addr), .rd_word(rd_data));

  always_comb begin
    rdy_d = pkt_ready;
    ovr_d = overrun;
    if (ack) begin
      rdy_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (pkt_done && !pkt_drop) rdy_d = 1'b1;
    if (pkt_done && pkt_drop)  ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pkt_ready <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      pkt_ready <= rdy_d;
      overrun   <= ovr_d;
    end
  end

  // Ready persists until acknowledged
  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pkt_ready && !ack) |=> pkt_ready);
  // Held buffer is never written
  assert_buffer_frozen_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    pkt_ready |-> !wr_en);
  // Overrun appears only while a packet is already held
  assert_overrun_when_held_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(overrun) |-> pkt_ready);
endmodule

// File: tb/frame_rx_test.sv
`timescale 1ns/1ps
module frame_rx_test;
  localparam int BT   = 8;
  localparam int IDLE = 800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_line;
  logic        ack;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;
  logic        pkt_ready;
  logic        overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] pkt  [16];
  logic [15:0] held [16];

  always #4 clk = ~clk;

  frame_rx #(.BIT_TICKS(BT), .IDLE_TICKS(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .ack(ack),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_ready(pkt_ready), .overrun(overrun));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rand_word(input int idx);
    // marker words keep runs of equal bits short
    if (idx == 5 || idx == 9 || idx == 13) return 16'hA55A;
    return 16'($urandom);
  endfunction

  function automatic logic [15:0] alt_word(input int idx);
    return (idx % 2 == 0) ? 16'h5555 : 16'h3333;
  endfunction

  task automatic hold_line(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_packet(input int period);
    hold_line(1'b0, period);
    for (int w = 0; w < 16; w++)
      for (int b = 15; b >= 0; b--)
        hold_line(pkt[w][b], period);
    rx_line = 1'b1;
  endtask

  task automatic check_buffer(input string req, input bit use_held);
    for (int w = 0; w < 16; w++) begin
      rd_addr = 4'(w);
      #1;
      check(req, 32'(rd_data), 32'(use_held ? held[w] : pkt[w]));
      @(negedge clk);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic fill_random();
    for (int w = 0; w < 16; w++) pkt[w] = rand_word(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rx_line = 1'b1; ack = 1'b0; rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(pkt_ready), 0);
    check("R1 overrun", 32'(overrun), 0);

    // R2 packet sent before the quiet interval has elapsed
    repeat (IDLE / 2) @(negedge clk);
    fill_random();
    send_packet(BT);
    repeat (4) @(negedge clk);
    check("R2 early packet ignored", 32'(pkt_ready), 0);

    // R2/R4/R5 armed packet
    hold_line(1'b1, IDLE + 2 * BT);
    fill_random();
    send_packet(BT);
    repeat (4) @(negedge clk);
    check("R5 ready set", 32'(pkt_ready), 1);
    check("R2 armed packet accepted", 32'(pkt_ready), 1);
    check_buffer("R4 data", 1'b0);
    for (int w = 0; w < 16; w++) held[w] = pkt[w];

    // R5 ready holds, R6 dropped packet
    hold_line(1'b1, IDLE + 2 * BT);
    check("R5 ready held", 32'(pkt_ready), 1);
    fill_random();
    send_packet(BT);
    repeat (4) @(negedge clk);
    check("R6 overrun set", 32'(overrun), 1);
    check("R6 ready still set", 32'(pkt_ready), 1);
    check_buffer("R6 buffer frozen", 1'b1);
    pulse_ack();
    check("R5 ack clears ready", 32'(pkt_ready), 0);
    check("R6 ack clears overrun", 32'(overrun), 0);

    // R3 glitch shorter than half a bit
    hold_line(1'b1, IDLE + 2 * BT);
    hold_line(1'b0, 2);
    hold_line(1'b1, IDLE + 2 * BT);
    check("R3 glitch no ready", 32'(pkt_ready), 0);
    fill_random();
    send_packet(BT);
    repeat (4) @(negedge clk);
    check("R3 ready after glitch", 32'(pkt_ready), 1);
    check_buffer("R3 data after glitch", 1'b0);
    pulse_ack();

    // R7 sender bit period off by one clock in each direction
    for (int k = 0; k < 2; k++) begin
      hold_line(1'b1, IDLE + 2 * BT);
      for (int w = 0; w < 16; w++) pkt[w] = alt_word(w);
      send_packet(k == 0 ? BT + 1 : BT - 1);
      repeat (4) @(negedge clk);
      check("R7 ready with drift", 32'(pkt_ready), 1);
      check_buffer("R7 data with drift", 1'b0);
      pulse_ack();
    end

    // R4 further random packets
    for (int k = 0; k < 3; k++) begin
      hold_line(1'b1, IDLE + 2 * BT);
      fill_random();
      send_packet(BT);
      repeat (4) @(negedge clk);
      check("R5 ready random", 32'(pkt_ready), 1);
      check_buffer("R4 random data", 1'b0);
      pulse_ack();
      check("R5 cleared random", 32'(pkt_ready), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule